// File: doc/BRIEF.md
# Pareto Front Dominance Filter

This block classifies a stored set of candidate processor realizations. Each candidate carries three unsigned fixed-point figures: a power cost, a throughput figure and an accuracy figure. Power is to be kept low. Throughput and accuracy are to be kept high. The filter flags every candidate that no other candidate dominates. It also counts how many such Pareto-optimal candidates exist. The set it leaves is the pool from which a controller later picks one operating point under its constraints.

The candidates live in a local RAM outside the block. The filter fetches them one at a time over a request/valid read port, and that port tolerates any number of wait cycles. For each outer candidate it fetches the candidate once and holds it in a register. It then fetches every other candidate in turn and tests whether that candidate dominates the held one. The verdict for each candidate leaves through a one-cycle flag write port. A done pulse closes the run. The filter works either on power and accuracy alone or on all three figures, and the mode is chosen at start.

Top module: `pareto_filter`

## Requirements
- R1: A start seen while idle with a non-zero candidate count makes busy high from the next cycle, and the first read request of the run addresses entry 0.
- R2: While a read request is pending without rd_valid, rd_req stays high and rd_idx stays unchanged. Returned data is taken only in a cycle with both rd_req and rd_valid high, and a stall of any length changes no result.
- R3: Outer entries are visited in ascending index order. For outer entry i, the block reads entry i once, then reads every other entry j in ascending order. It never reads entry i during its own inner scan.
- R4: In 3-objective mode (three_obj = 1), entry j dominates entry i when all three hold: power_j <= power_i, perf_j >= perf_i and acc_j >= acc_i. At least one of those comparisons must also be strict.
- R5: In 2-objective mode (three_obj = 0), throughput plays no part, and dominance uses power (lower is better) and accuracy (higher is better) only. The mode is sampled at the start cycle.
- R6: Two entries with identical active figures do not dominate each other. Both stay flagged optimal unless a third entry dominates them.
- R7: After the inner scan of entry i, exactly one cycle has flag_we high, with flag_idx = i. In that cycle flag_opt = 1 if no other entry dominates entry i, and flag_opt = 0 otherwise.
- R8: opt_count is cleared at start and rises by one for each flag write with flag_opt = 1. It holds its final value after done until the next accepted start.
- R9: done is high for exactly one cycle, in the cycle after the last flag write. busy is low in the cycle after done.
- R10: A start asserted while busy is high is ignored. The run in progress continues with its sampled count and mode, and its reads, flags and count are unchanged.
- R11: n_cand is sampled at start and clamped to MAX_CAND. A count of 0 gives done in the next cycle with opt_count = 0 and no read. A count of 1 flags entry 0 optimal after one read with no inner read.
- R12: After reset, busy, done, rd_req and flag_we are low, and opt_count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| three_obj | input | 1 | 1: three objectives, 0: power and accuracy only |
| n_cand | input | CNT_W | Number of stored candidates |
| rd_req | output | 1 | Read request to the candidate RAM |
| rd_idx | output | IDX_W | Entry index being read |
| rd_valid | input | 1 | Read data is valid for the pending request |
| rd_power | input | PWR_W | Power figure of the entry read |
| rd_perf | input | PERF_W | Throughput figure of the entry read |
| rd_acc | input | ACC_W | Accuracy figure of the entry read |
| flag_we | output | 1 | Flag write strobe |
| flag_idx | output | IDX_W | Entry whose flag is written |
| flag_opt | output | 1 | 1 when the entry is Pareto-optimal |
| opt_count | output | CNT_W | Number of optimal entries in the run |
| busy | output | 1 | Run in progress, including the done cycle |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach is a dominance verdict that the active mode and ties decide. One example is an entry that only throughput keeps on the front. Another is a pair of exact duplicates. In both, the verdict depends on a strict comparison on just one figure. The bench runs the same hand-built table in both modes, adds duplicate rows and draws small-range random tables so that ties are frequent. It also runs with a pseudo-random stall on rd_valid, so that outer and inner fetches arrive with varied gaps, and pulses start mid-run to show that the run holds on.

// File: rtl/pareto_pkg.sv
package pareto_pkg;
  typedef enum logic [2:0] {
    PF_IDLE,
    PF_OUTER,
    PF_INNER,
    PF_WRITE,
    PF_DONE
  } pf_state_e;
endpackage

// File: rtl/pf_dominance.sv
module pf_dominance #(
  parameter int PWR_W  = 12,
  parameter int PERF_W = 12,
  parameter int ACC_W  = 10
) (
  input  logic              three_obj,
  input  logic [PWR_W-1:0]  ch_pwr,
  input  logic [PERF_W-1:0] ch_perf,
  input  logic [ACC_W-1:0]  ch_acc,
  input  logic [PWR_W-1:0]  hd_pwr,
  input  logic [PERF_W-1:0] hd_perf,
  input  logic [ACC_W-1:0]  hd_acc,
  output logic              dominated
);
  // challenger is at least as good as the held entry on every active figure
  function automatic logic no_worse(
    input logic [PWR_W-1:0] cp, input logic [PERF_W-1:0] cf, input logic [ACC_W-1:0] ca,
    input logic [PWR_W-1:0] hp, input logic [PERF_W-1:0] hf, input logic [ACC_W-1:0] ha,
    input logic use_perf);
    return (cp <= hp) && (ca >= ha) && (!use_perf || (cf >= hf));
  endfunction

  // challenger is strictly better on at least one active figure
  function automatic logic some_better(
    input logic [PWR_W-1:0] cp, input logic [PERF_W-1:0] cf, input logic [ACC_W-1:0] ca,
    input logic [PWR_W-1:0] hp, input logic [PERF_W-1:0] hf, input logic [ACC_W-1:0] ha,
    input logic use_perf);
    return (cp < hp) || (ca > ha) || (use_perf && (cf > hf));
  endfunction

  always_comb begin
    dominated = no_worse(ch_pwr, ch_perf, ch_acc, hd_pwr, hd_perf, hd_acc, three_obj) &&
                some_better(ch_pwr, ch_perf, ch_acc, hd_pwr, hd_perf, hd_acc, three_obj);
  end
endmodule

// File: rtl/pf_seq.sv
module pf_seq
  import pareto_pkg::*;
#(
  parameter int  MAX_CAND = 16,
  localparam int IDX_W    = (MAX_CAND > 1) ? $clog2(MAX_CAND) : 1,
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] n_cand,
  input  logic             rd_valid,
  output logic             rd_req,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] outer_idx,
  output logic             launch,
  output logic             accept_out,
  output logic             accept_in,
  output logic             in_inner,
  output logic             wr_fire,
  output logic             busy,
  output logic             done
);
  pf_state_e        st;
  logic [CNT_W-1:0] oi, ij, n_lat;
  logic [CNT_W-1:0] first_j, next_j, n_clamped;

  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] req);
    return (req > CNT_W'(MAX_CAND)) ? CNT_W'(MAX_CAND) : req;
  endfunction

  // next inner index after j, stepping over the outer entry
  function automatic logic [CNT_W-1:0] step_inner(input logic [CNT_W-1:0] j,
                                                  input logic [CNT_W-1:0] skip);
    logic [CNT_W-1:0] nx;
    nx = j + CNT_W'(1);
    if (nx == skip) nx = nx + CNT_W'(1);
    return nx;
  endfunction

  assign n_clamped = clamp_count(n_cand);
  assign first_j   = (oi == '0) ? CNT_W'(1) : '0;
  assign next_j    = step_inner(ij, oi);

  assign launch     = (st == PF_IDLE) && start;
  assign in_inner   = (st == PF_INNER);
  assign accept_out = (st == PF_OUTER) && rd_valid;
  assign accept_in  = in_inner && rd_valid;
  assign wr_fire    = (st == PF_WRITE);
  assign rd_req     = (st == PF_OUTER) || in_inner;
  assign rd_idx     = in_inner ? IDX_W'(ij) : IDX_W'(oi);
  assign outer_idx  = IDX_W'(oi);
  assign busy       = (st != PF_IDLE);
  assign done       = (st == PF_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PF_IDLE;
      oi    <= '0;
      ij    <= '0;
      n_lat <= '0;
    end else begin
      case (st)
        PF_IDLE: if (start) begin
          n_lat <= n_clamped;
          oi    <= '0;
          st    <= (n_clamped == '0) ? PF_DONE : PF_OUTER;
        end
        PF_OUTER: if (rd_valid) begin
          if (first_j >= n_lat) st <= PF_WRITE;
          else begin
            ij <= first_j;
            st <= PF_INNER;
          end
        end
        PF_INNER: if (rd_valid) begin
          if (next_j >= n_lat) st <= PF_WRITE;
          else ij <= next_j;
        end
        PF_WRITE: begin
          if (oi + CNT_W'(1) >= n_lat) st <= PF_DONE;
          else begin
            oi <= oi + CNT_W'(1);
            st <= PF_OUTER;
          end
        end
        PF_DONE: st <= PF_IDLE;
        default: st <= PF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pareto_filter.sv
module pareto_filter #(
  parameter int  MAX_CAND = 16,
  parameter int  PWR_W    = 12,
  parameter int  PERF_W   = 12,
  parameter int  ACC_W    = 10,
  localparam int IDX_W    = (MAX_CAND > 1) ? $clog2(MAX_CAND) : 1,
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              three_obj,
  input  logic [CNT_W-1:0]  n_cand,
  output logic              rd_req,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic [PWR_W-1:0]  rd_power,
  input  logic [PERF_W-1:0] rd_perf,
  input  logic [ACC_W-1:0]  rd_acc,
  output logic              flag_we,
  output logic [IDX_W-1:0]  flag_idx,
  output logic              flag_opt,
  output logic [CNT_W-1:0]  opt_count,
  output logic              busy,
  output logic              done
);
  // named internal events, also observed by the bound checker
  logic             launch, accept_out, accept_in, in_inner, wr_fire, dom_hit;
  logic [IDX_W-1:0] outer_idx;

  logic              mode_q, dom_q;
  logic [PWR_W-1:0]  held_pwr;
  logic [PERF_W-1:0] held_perf;
  logic [ACC_W-1:0]  held_acc;
  logic [CNT_W-1:0]  count_q;

  pf_seq #(.MAX_CAND(MAX_CAND)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .n_cand     (n_cand),
    .rd_valid   (rd_valid),
    .rd_req     (rd_req),
    .rd_idx     (rd_idx),
    .outer_idx  (outer_idx),
    .launch     (launch),
    .accept_out (accept_out),
    .accept_in  (accept_in),
    .in_inner   (in_inner),
    .wr_fire    (wr_fire),
    .busy       (busy),
    .done       (done)
  );

  pf_dominance #(.PWR_W(PWR_W), .PERF_W(PERF_W), .ACC_W(ACC_W)) u_dom (
    .three_obj (mode_q),
    .ch_pwr    (rd_power),
    .ch_perf   (rd_perf),
    .ch_acc    (rd_acc),
    .hd_pwr    (held_pwr),
    .hd_perf   (held_perf),
    .hd_acc    (held_acc),
    .dominated (dom_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      dom_q     <= 1'b0;
      held_pwr  <= '0;
      held_perf <= '0;
      held_acc  <= '0;
      count_q   <= '0;
    end else begin
      if (launch) begin
        mode_q  <= three_obj;
        count_q <= '0;
      end
      if (accept_out) begin
        held_pwr  <= rd_power;
        held_perf <= rd_perf;
        held_acc  <= rd_acc;
        dom_q     <= 1'b0;
      end else if (accept_in && dom_hit) begin
        dom_q <= 1'b1;
      end
      if (wr_fire && !dom_q) count_q <= count_q + CNT_W'(1);
    end
  end

  assign flag_we   = wr_fire;
  assign flag_idx  = outer_idx;
  assign flag_opt  = !dom_q;
  assign opt_count = count_q;
endmodule

// File: rtl/pareto_filter_chk.sv
module pareto_filter_chk #(
  parameter int  MAX_CAND = 16,
  localparam int IDX_W    = (MAX_CAND > 1) ? $clog2(MAX_CAND) : 1,
  localparam int CNT_W    = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             rd_valid,
  input logic [IDX_W-1:0] rd_idx,
  input logic [IDX_W-1:0] outer_idx,
  input logic             in_inner,
  input logic             launch,
  input logic             flag_we,
  input logic             flag_opt,
  input logic [CNT_W-1:0] opt_count,
  input logic             busy,
  input logic             done
);
  // R1
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R2
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_idx));

  // R3
  self_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_inner |-> rd_idx != outer_idx);

  // R7
  flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> !flag_we);

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_we && flag_opt) && !launch |=> $stable(opt_count));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !flag_we && !done);
endmodule

bind pareto_filter pareto_filter_chk #(.MAX_CAND(MAX_CAND)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .rd_idx    (rd_idx),
  .outer_idx (outer_idx),
  .in_inner  (in_inner),
  .launch    (launch),
  .flag_we   (flag_we),
  .flag_opt  (flag_opt),
  .opt_count (opt_count),
  .busy      (busy),
  .done      (done)
);

// File: tb/pareto_filter_test.sv
`timescale 1ns/1ps
module pareto_filter_test;
  localparam int MAXC  = 8;
  localparam int IDX_W = 3;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic three_obj = 1'b0;
  logic [CNT_W-1:0] n_cand = '0;
  logic rd_req, rd_valid, flag_we, flag_opt, busy, done;
  logic [IDX_W-1:0] rd_idx, flag_idx;
  logic [11:0] rd_power, rd_perf;
  logic [9:0]  rd_acc;
  logic [CNT_W-1:0] opt_count;

  logic [11:0] mem_p [MAXC];
  logic [11:0] mem_f [MAXC];
  logic [9:0]  mem_a [MAXC];

  logic stall = 1'b0;
  logic stall_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  assign rd_valid = rd_req && !stall;
  assign rd_power = mem_p[rd_idx];
  assign rd_perf  = mem_f[rd_idx];
  assign rd_acc   = mem_a[rd_idx];

  pareto_filter #(.MAX_CAND(MAXC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .three_obj(three_obj), .n_cand(n_cand),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_power(rd_power),
    .rd_perf(rd_perf), .rd_acc(rd_acc), .flag_we(flag_we), .flag_idx(flag_idx),
    .flag_opt(flag_opt), .opt_count(opt_count), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(posedge clk);
    #1;
    if (stall_on) begin
      lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stall = lfsr[0] | lfsr[3];
    end else stall = 1'b0;
  end

  // reference model state
  int  exp_rd[$];
  int  exp_wr[$];
  bit  exp_flag [MAXC];
  int  exp_cnt = 0;
  int  last_evt = 0;
  int  start_cyc = 0;
  bit  run_pending = 1'b0;
  bit  in_run = 1'b0;
  bit  run_done = 1'b0;

  // cost view: every objective turned into "lower is better"
  function automatic bit beats(input int j, input int i, input bit three);
    int cj[3];
    int ci[3];
    bit all_le, any_lt;
    cj[0] = -int'(mem_a[j]); ci[0] = -int'(mem_a[i]);
    cj[1] = int'(mem_p[j]);  ci[1] = int'(mem_p[i]);
    cj[2] = three ? -int'(mem_f[j]) : 0;
    ci[2] = three ? -int'(mem_f[i]) : 0;
    all_le = 1'b1; any_lt = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (cj[k] > ci[k]) all_le = 1'b0;
      if (cj[k] < ci[k]) any_lt = 1'b1;
    end
    return all_le && any_lt;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (run_pending && cyc > start_cyc) begin
        in_run = 1'b1;
        run_pending = 1'b0;
      end
      if (!in_run)
        check(!(rd_req || flag_we || done || busy), "R12 quiet outside run", busy, 0);
      else
        check(busy, "R1 busy during run", busy, 1);
      if (rd_req && rd_valid) begin
        if (exp_rd.size() == 0) check(1'b0, "R3 unexpected read", rd_idx, -1);
        else begin
          int e;
          e = exp_rd.pop_front();
          check(rd_idx == IDX_W'(e), "R3 read order", rd_idx, e);
        end
      end
      if (flag_we) begin
        if (exp_wr.size() == 0) check(1'b0, "R7 unexpected flag write", flag_idx, -1);
        else begin
          int e;
          e = exp_wr.pop_front();
          check(flag_idx == IDX_W'(e), "R7 flag index", flag_idx, e);
          check(flag_opt == exp_flag[e], "R4 R5 R6 flag value", flag_opt, exp_flag[e]);
        end
        last_evt = cyc;
      end
      if (done) begin
        check(in_run, "R9 done outside run", 0, 1);
        check(cyc == last_evt + 1, "R9 done timing", cyc, last_evt + 1);
        check(exp_rd.size() == 0 && exp_wr.size() == 0, "R3 all entries visited",
              exp_rd.size() + exp_wr.size(), 0);
        check(opt_count == CNT_W'(exp_cnt), "R8 optimal count", opt_count, exp_cnt);
        in_run = 1'b0;
        run_done = 1'b1;
      end
    end
  end

  task automatic run(input int n_req, input bit three, input bit poke_busy, input string tag);
    int n_eff;
    int wd;
    n_eff = (n_req > MAXC) ? MAXC : n_req;
    exp_rd.delete();
    exp_wr.delete();
    exp_cnt = 0;
    for (int i = 0; i < n_eff; i++) begin
      bit beaten;
      beaten = 1'b0;
      exp_rd.push_back(i);
      for (int j = 0; j < n_eff; j++) begin
        if (j != i) begin
          exp_rd.push_back(j);
          if (beats(j, i, three)) beaten = 1'b1;
        end
      end
      exp_flag[i] = !beaten;
      if (!beaten) exp_cnt++;
      exp_wr.push_back(i);
    end
    @(posedge clk);
    #1;
    start = 1'b1;
    three_obj = three;
    n_cand = CNT_W'(n_req);
    start_cyc = cyc;
    last_evt = cyc;
    run_pending = 1'b1;
    run_done = 1'b0;
    @(posedge clk);
    #1;
    start = 1'b0;
    three_obj = ~three;
    n_cand = CNT_W'(1);
    if (poke_busy) begin
      // R10: pulse start with another count and mode while busy
      repeat (5) @(posedge clk);
      #1;
      start = 1'b1;
      @(posedge clk);
      #1;
      start = 1'b0;
    end
    wd = 0;
    while (!run_done && wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    check(run_done, {"watchdog ", tag}, 0, 1);
    if (!run_done) begin
      in_run = 1'b0;
      run_pending = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1;
    check(opt_count == CNT_W'(exp_cnt), {"R8 count held after done ", tag}, opt_count, exp_cnt);
    check(!busy, {"R9 idle after done ", tag}, busy, 0);
  endtask

  task automatic load(input int k, input int p, input int f, input int a);
    mem_p[k] = 12'(p);
    mem_f[k] = 12'(f);
    mem_a[k] = 10'(a);
  endtask

  task automatic load_table_a();
    load(0, 10, 50, 30);
    load(1, 12, 40, 30);
    load(2, 20, 90, 40);
    load(3, 15, 30, 45);
    load(4, 30, 60, 20);
    load(5, 10, 50, 30);
    load(6,  8, 20, 25);
    load(7, 40, 95, 50);
  endtask

  task automatic load_random(input int seed);
    int s;
    s = seed;
    for (int k = 0; k < MAXC; k++) begin
      s = s * 1103515245 + 12345;
      mem_p[k] = 12'((s >>> 16) & 7);
      s = s * 1103515245 + 12345;
      mem_f[k] = 12'((s >>> 16) & 7);
      s = s * 1103515245 + 12345;
      mem_a[k] = 10'((s >>> 16) & 7);
    end
  endtask

  initial begin
    load_table_a();
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    check(!busy && !done && !rd_req && !flag_we, "R12 reset outputs", busy, 0);
    check(opt_count == '0, "R12 reset count", opt_count, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    run(8, 1'b1, 1'b0, "R4 table three-obj");
    run(8, 1'b0, 1'b0, "R5 table two-obj");
    stall_on = 1'b1;
    run(8, 1'b1, 1'b0, "R2 stalled three-obj");
    run(8, 1'b0, 1'b1, "R10 start while busy");
    stall_on = 1'b0;

    // R6: duplicate rows
    for (int k = 0; k < MAXC; k++) load(k, 5 + (k % 2) * 10, 40, 20 - (k % 2) * 5);
    run(6, 1'b1, 1'b0, "R6 duplicates");

    load_table_a();
    run(1, 1'b1, 1'b0, "R11 single entry");
    run(0, 1'b0, 1'b0, "R11 empty set");
    run(13, 1'b1, 1'b0, "R11 clamp");

    stall_on = 1'b1;
    for (int t = 0; t < 6; t++) begin
      load_random(17 + t * 31);
      run(3 + t, t[0], 1'b0, "R4 R5 random");
    end
    stall_on = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule